// File: doc/BRIEF.md
# DDR SDRAM Command Protocol Checker

This block is a passive monitor that sits beside a DDR SDRAM command bus and watches what a memory controller issues. On every rising clock edge it decodes the strobe pattern into a command. It keeps a small state machine for each of the four banks, and it runs timers that measure the spacing between related commands. When a command breaks an ordering or timing rule, the monitor pulses an error strobe. The strobe carries a rule code and the offending bank. The monitor also sets a sticky flag for that rule, which stays set until reset. A controller testbench instantiates it next to the memory model and reads the flags at the end of a run.

Every timing limit is a parameter given in picoseconds. Each one is turned into a clock count by ceiling division by the clock period parameter, and the result is never below one cycle. The monitor drives nothing on the memory bus. It has no data-path capture and does not interpret mode register contents. The burst length needed for burst-end timing is a parameter.

Each bank state machine has four states:
- `B_IDLE`: no row is open.
- `B_ACTIVE`: a row is open.
- `B_PRECHG`: an explicit precharge is in progress.
- `B_AUTOPRE`: a read or write with auto-precharge is pending.

The transitions are:
- `B_IDLE` to `B_ACTIVE` on activate.
- `B_ACTIVE` to `B_ACTIVE` on a repeated activate.
- `B_ACTIVE` to `B_PRECHG` on precharge.
- `B_ACTIVE` to `B_AUTOPRE` on a read or write with the auto-precharge bit set.
- `B_PRECHG` or `B_AUTOPRE` to `B_IDLE` when the recovery timer reaches zero.
- `B_PRECHG` or `B_AUTOPRE` to `B_ACTIVE` on activate.

Top module: `ddr_cmd_monitor`

## Requirements
- R1: A command is decoded only when `clk_en` is high at both the previous and the current edge and `chip_sel_n` is low. The command code is {`row_strobe_n`,`col_strobe_n`,`wr_en_n`}:
  - 000: mode set
  - 001: refresh
  - 011: activate
  - 101: read
  - 100: write
  - 110: burst stop
  - 010: precharge
  - 111: no operation

  Any other edge has no effect on state or errors.
- R2: Bank index i = {bank_addr[1], bank_addr[0]} selects the bank. `bank_open[i]` is high while bank i holds an open row.
- R3: An activate to a bank with an open row reports rule 3. A read or write to a bank with no open row reports rule 8. A precharge of a bank without an open row is legal and changes nothing.
- R4: A read or write less than ceil(tRCD/tCK) cycles after the activate of its bank reports rule 9.
- R5: A precharge less than ceil(tRAS/tCK) cycles after the activate of its bank reports rule 12.
- R6: An activate less than ceil(tRP/tCK) cycles after a precharge of the same bank reports rule 4. An activate less than ceil(tRC/tCK) cycles after the previous activate of that bank reports rule 5.
- R7: An activate less than ceil(tRRD/tCK) cycles after any other activate reports rule 7.
- R8: A mode set or refresh while any bank is open or still recovering reports rule 2. The reported bank is the lowest such bank.
- R9: Any command less than the mode-set gap (2 cycles) after a mode set reports rule 1. This rule takes priority over every other rule.
- R10: A precharge with `auto_pre_bit` high applies to all banks and ignores `bank_addr`. A violation is reported against the lowest bank that breaks its rule.
- R11: A read or write with `auto_pre_bit` high closes the bank automatically:
  - Another read or write to that bank before it is reactivatable reports rule 10.
  - An activate to it is legal only at max(remaining tRAS, BL/2 + W) + ceil(tRP/tCK) cycles after the command, where W is ceil(tWR/tCK) for a write and 0 for a read. Earlier, it reports rule 6.
- R12: A read less than BL/2 + the write-to-read gap (1) cycles after any write reports rule 11.
- R13: A violation at edge k gives `err_valid` high for exactly the cycle after edge k, with `err_rule` and `err_bank`. It also sets `err_sticky[err_rule-1]`. Sticky bits only clear on reset. At most one rule is reported per edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory command clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Clock-enable line of the memory bus |
| chip_sel_n | input | 1 | Active-low chip select |
| row_strobe_n | input | 1 | Active-low row strobe |
| col_strobe_n | input | 1 | Active-low column strobe |
| wr_en_n | input | 1 | Active-low write enable |
| bank_addr | input | BA_W | Bank select |
| auto_pre_bit | input | 1 | All-bank precharge / auto-precharge address bit |
| bank_open | output | 2**BA_W | Per-bank open-row indicator |
| err_valid | output | 1 | One-cycle violation strobe |
| err_rule | output | 4 | Rule code of the reported violation |
| err_bank | output | BA_W | Bank of the reported violation |
| err_sticky | output | 12 | Sticky per-rule flags, bit n for rule n+1 |

## Verification
The embedded properties check the following on every cycle:
- Sticky flags never clear.
- Each strobe is backed by its sticky bit.
- At most one new flag appears per edge.
- Nothing is reported after an edge where the clock enable was low.
- An activate always opens its bank.
- A mode set with a busy bank always yields rule 2.

The cycle-exact limits of each timer can only be shown by the directed scenarios, which issue commands one cycle before and exactly at each limit. These limits are tRCD, tRAS, tRP, tRRD, the mode-set gap, the auto-precharge window and the write-to-read spacing. The same scenarios are needed to show bank numbering, priority between rules and the all-bank precharge choice.

// File: rtl/ddrmon_pkg.sv
package ddrmon_pkg;

    typedef enum logic [2:0] {
        C_NONE, C_MRS, C_REF, C_ACT, C_RD, C_WR, C_BST, C_PRE
    } cmd_e;

    typedef enum logic [3:0] {
        RULE_NONE     = 4'd0,
        RULE_MRD_GAP  = 4'd1,
        RULE_NOT_IDLE = 4'd2,
        RULE_ACT_OPEN = 4'd3,
        RULE_TRP      = 4'd4,
        RULE_TRC      = 4'd5,
        RULE_AP_BUSY  = 4'd6,
        RULE_TRRD     = 4'd7,
        RULE_COL_IDLE = 4'd8,
        RULE_TRCD     = 4'd9,
        RULE_AP_COL   = 4'd10,
        RULE_TWTR     = 4'd11,
        RULE_TRAS     = 4'd12
    } rule_e;

    localparam int NUM_RULES = 12;

    typedef enum logic [1:0] {
        B_IDLE, B_ACTIVE, B_PRECHG, B_AUTOPRE
    } bank_st_e;

    // Ceiling conversion from picoseconds to clocks, never below one cycle.
    function automatic int ck_of(input int ps, input int ck_ps);
        int c;
        c = (ps + ck_ps - 1) / ck_ps;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/ddrmon_decode.sv
module ddrmon_decode
    import ddrmon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clk_en,
    input  logic chip_sel_n,
    input  logic row_strobe_n,
    input  logic col_strobe_n,
    input  logic wr_en_n,
    output cmd_e cmd
);
    logic clk_en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) clk_en_q <= 1'b0;
        else        clk_en_q <= clk_en;
    end

    always_comb begin
        cmd = C_NONE;
        if (clk_en && clk_en_q && !chip_sel_n) begin
            unique case ({row_strobe_n, col_strobe_n, wr_en_n})
                3'b000: cmd = C_MRS;
                3'b001: cmd = C_REF;
                3'b011: cmd = C_ACT;
                3'b101: cmd = C_RD;
                3'b100: cmd = C_WR;
                3'b110: cmd = C_BST;
                3'b010: cmd = C_PRE;
                3'b111: cmd = C_NONE;
            endcase
        end
    end

endmodule

// File: rtl/ddrmon_bank.sv
module ddrmon_bank
    import ddrmon_pkg::*;
#(
    parameter int RCD_CK  = 3,
    parameter int RAS_CK  = 7,
    parameter int RC_CK   = 10,
    parameter int RP_CK   = 3,
    parameter int WR_CK   = 3,
    parameter int HALF_BL = 2,
    parameter int CW      = 5
) (
    input  logic  clk,
    input  logic  rst_n,
    input  cmd_e  cmd,
    input  logic  sel,
    input  logic  ap,
    output rule_e viol,
    output logic  ready,
    output logic  open
);
    localparam logic [CW-1:0] RCD_LD = CW'(RCD_CK - 1);
    localparam logic [CW-1:0] RAS_LD = CW'(RAS_CK - 1);
    localparam logic [CW-1:0] RC_LD  = CW'(RC_CK - 1);
    localparam logic [CW-1:0] RP_LD  = CW'(RP_CK - 1);
    localparam logic [CW-1:0] RD_BURST = CW'(HALF_BL);
    localparam logic [CW-1:0] WR_BURST = CW'(HALF_BL + WR_CK);

    bank_st_e        state_q, state_d;
    logic [CW-1:0]   rcd_q, rcd_d, ras_q, ras_d, rc_q, rc_d, pre_q, pre_d;
    logic [CW-1:0]   burst_ck, hold_ck, ap_ld;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= B_IDLE;
            rcd_q   <= '0;
            ras_q   <= '0;
            rc_q    <= '0;
            pre_q   <= '0;
        end else begin
            state_q <= state_d;
            rcd_q   <= rcd_d;
            ras_q   <= ras_d;
            rc_q    <= rc_d;
            pre_q   <= pre_d;
        end
    end

    // auto-precharge hold: later of tRAS end and burst (+recovery), then tRP
    always_comb begin
        burst_ck = (cmd == C_WR) ? WR_BURST : RD_BURST;
        hold_ck  = (ras_q > burst_ck) ? ras_q : burst_ck;
        ap_ld    = hold_ck + RP_LD;
    end

    // next state and timers
    always_comb begin
        state_d = state_q;
        rcd_d   = (rcd_q != '0) ? rcd_q - 1'b1 : rcd_q;
        ras_d   = (ras_q != '0) ? ras_q - 1'b1 : ras_q;
        rc_d    = (rc_q  != '0) ? rc_q  - 1'b1 : rc_q;
        pre_d   = (pre_q != '0) ? pre_q - 1'b1 : pre_q;
        if (sel && cmd == C_ACT) begin
            state_d = B_ACTIVE;
            rcd_d   = RCD_LD;
            ras_d   = RAS_LD;
            rc_d    = RC_LD;
        end else begin
            unique case (state_q)
                B_IDLE: ;
                B_ACTIVE: begin
                    if (sel && cmd == C_PRE) begin
                        state_d = B_PRECHG;
                        pre_d   = RP_LD;
                    end else if (sel && ap && (cmd == C_RD || cmd == C_WR)) begin
                        state_d = B_AUTOPRE;
                        pre_d   = ap_ld;
                    end
                end
                B_PRECHG, B_AUTOPRE: begin
                    if (pre_q == '0) state_d = B_IDLE;
                end
            endcase
        end
    end

    // outputs: rule broken by the command presented to this bank
    always_comb begin
        viol = RULE_NONE;
        if (sel) begin
            case (cmd)
                C_ACT: begin
                    if (state_q == B_ACTIVE)                         viol = RULE_ACT_OPEN;
                    else if (state_q == B_PRECHG && pre_q != '0)     viol = RULE_TRP;
                    else if (state_q == B_AUTOPRE && pre_q != '0)    viol = RULE_AP_BUSY;
                    else if (rc_q != '0)                             viol = RULE_TRC;
                end
                C_RD, C_WR: begin
                    if (state_q == B_AUTOPRE && pre_q != '0)         viol = RULE_AP_COL;
                    else if (state_q == B_ACTIVE) begin
                        if (rcd_q != '0)                             viol = RULE_TRCD;
                    end else                                         viol = RULE_COL_IDLE;
                end
                C_PRE: begin
                    if (state_q == B_ACTIVE && ras_q != '0)          viol = RULE_TRAS;
                end
                default: viol = RULE_NONE;
            endcase
        end
        open  = (state_q == B_ACTIVE);
        ready = (state_q == B_IDLE) ||
                ((state_q == B_PRECHG || state_q == B_AUTOPRE) && pre_q == '0);
    end

    // R3: an activate always leaves the bank with an open row
    p_act_opens_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && cmd == C_ACT) |=> (state_q == B_ACTIVE));

    // R10: a precharge of an open bank starts recovery
    p_pre_closes_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && cmd == C_PRE && state_q == B_ACTIVE) |=> (state_q == B_PRECHG));

    // R11: a pending auto-precharge is not left early except by activate
    p_ap_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == B_AUTOPRE && pre_q != '0 && !(sel && cmd == C_ACT))
        |=> (state_q == B_AUTOPRE));

endmodule

// File: rtl/ddr_cmd_monitor.sv
module ddr_cmd_monitor
    import ddrmon_pkg::*;
#(
    parameter int T_CK_PS   = 6000,
    parameter int T_RCD_PS  = 18000,
    parameter int T_RP_PS   = 18000,
    parameter int T_RAS_PS  = 42000,
    parameter int T_RC_PS   = 60000,
    parameter int T_RRD_PS  = 12000,
    parameter int T_WR_PS   = 15000,
    parameter int WTR_CK    = 1,
    parameter int MRD_CK    = 2,
    parameter int BURST_LEN = 4,
    parameter int BA_W      = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clk_en,
    input  logic                 chip_sel_n,
    input  logic                 row_strobe_n,
    input  logic                 col_strobe_n,
    input  logic                 wr_en_n,
    input  logic [BA_W-1:0]      bank_addr,
    input  logic                 auto_pre_bit,
    output logic [(1<<BA_W)-1:0] bank_open,
    output logic                 err_valid,
    output logic [3:0]           err_rule,
    output logic [BA_W-1:0]      err_bank,
    output logic [NUM_RULES-1:0] err_sticky
);
    localparam int NB       = 1 << BA_W;
    localparam int RCD_CK   = ck_of(T_RCD_PS, T_CK_PS);
    localparam int RP_CK    = ck_of(T_RP_PS,  T_CK_PS);
    localparam int RAS_CK   = ck_of(T_RAS_PS, T_CK_PS);
    localparam int RC_CK    = ck_of(T_RC_PS,  T_CK_PS);
    localparam int RRD_CK   = ck_of(T_RRD_PS, T_CK_PS);
    localparam int WR_CK    = ck_of(T_WR_PS,  T_CK_PS);
    localparam int HALF_BL  = BURST_LEN / 2;
    localparam int WTR_SPAN = HALF_BL + WTR_CK;
    localparam int CW       = $clog2(RAS_CK + RC_CK + HALF_BL + WR_CK + RP_CK + 1);
    localparam int XW       = $clog2(MRD_CK + RRD_CK + WTR_SPAN + 1);

    cmd_e             cmd;
    rule_e            bank_viol [NB];
    logic [NB-1:0]    bank_sel, bank_ready;
    logic [XW-1:0]    mrd_q, mrd_d, rrd_q, rrd_d, wtr_q, wtr_d;
    rule_e            hit, pall_hit;
    logic [BA_W-1:0]  hit_bank, first_busy, first_viol;
    logic             all_ready;
    logic [NUM_RULES-1:0] hit_mask;

    ddrmon_decode u_decode (
        .clk          (clk),
        .rst_n        (rst_n),
        .clk_en       (clk_en),
        .chip_sel_n   (chip_sel_n),
        .row_strobe_n (row_strobe_n),
        .col_strobe_n (col_strobe_n),
        .wr_en_n      (wr_en_n),
        .cmd          (cmd)
    );

    for (genvar i = 0; i < NB; i++) begin : g_bank
        assign bank_sel[i] = (cmd == C_PRE && auto_pre_bit) ||
                             ((cmd == C_ACT || cmd == C_RD || cmd == C_WR || cmd == C_PRE)
                              && bank_addr == BA_W'(i));
        ddrmon_bank #(
            .RCD_CK  (RCD_CK),
            .RAS_CK  (RAS_CK),
            .RC_CK   (RC_CK),
            .RP_CK   (RP_CK),
            .WR_CK   (WR_CK),
            .HALF_BL (HALF_BL),
            .CW      (CW)
        ) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .cmd   (cmd),
            .sel   (bank_sel[i]),
            .ap    (auto_pre_bit),
            .viol  (bank_viol[i]),
            .ready (bank_ready[i]),
            .open  (bank_open[i])
        );
    end

    assign all_ready = &bank_ready;

    // cross-bank spacing timers
    always_comb begin
        mrd_d = (mrd_q != '0) ? mrd_q - 1'b1 : mrd_q;
        rrd_d = (rrd_q != '0) ? rrd_q - 1'b1 : rrd_q;
        wtr_d = (wtr_q != '0) ? wtr_q - 1'b1 : wtr_q;
        if (cmd == C_MRS) mrd_d = XW'(MRD_CK - 1);
        if (cmd == C_ACT) rrd_d = XW'(RRD_CK - 1);
        if (cmd == C_WR)  wtr_d = XW'(WTR_SPAN - 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mrd_q <= '0;
            rrd_q <= '0;
            wtr_q <= '0;
        end else begin
            mrd_q <= mrd_d;
            rrd_q <= rrd_d;
            wtr_q <= wtr_d;
        end
    end

    // lowest busy bank and lowest violating bank
    always_comb begin
        first_busy = '0;
        first_viol = '0;
        pall_hit   = RULE_NONE;
        for (int i = NB - 1; i >= 0; i--) begin
            if (!bank_ready[i]) first_busy = BA_W'(i);
            if (bank_viol[i] != RULE_NONE) begin
                first_viol = BA_W'(i);
                pall_hit   = bank_viol[i];
            end
        end
    end

    // one rule per edge, by priority
    always_comb begin
        hit      = RULE_NONE;
        hit_bank = bank_addr;
        if (cmd != C_NONE && mrd_q != '0) begin
            hit = RULE_MRD_GAP;
        end else begin
            case (cmd)
                C_MRS, C_REF: begin
                    if (!all_ready) begin
                        hit      = RULE_NOT_IDLE;
                        hit_bank = first_busy;
                    end
                end
                C_ACT: begin
                    hit = bank_viol[bank_addr];
                    if (hit == RULE_NONE && rrd_q != '0) hit = RULE_TRRD;
                end
                C_RD: begin
                    hit = bank_viol[bank_addr];
                    if (hit == RULE_NONE && wtr_q != '0) hit = RULE_TWTR;
                end
                C_WR: hit = bank_viol[bank_addr];
                C_PRE: begin
                    if (auto_pre_bit) begin
                        hit      = pall_hit;
                        hit_bank = first_viol;
                    end else begin
                        hit = bank_viol[bank_addr];
                    end
                end
                default: hit = RULE_NONE;
            endcase
        end
        for (int i = 0; i < NUM_RULES; i++)
            hit_mask[i] = (hit == rule_e'(4'(i + 1)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_valid  <= 1'b0;
            err_rule   <= '0;
            err_bank   <= '0;
            err_sticky <= '0;
        end else begin
            err_valid  <= (hit != RULE_NONE);
            err_rule   <= hit;
            err_bank   <= hit_bank;
            err_sticky <= err_sticky | hit_mask;
        end
    end

    // R13: sticky flags never clear outside reset
    p_sticky_keep_r13: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((err_sticky & $past(err_sticky)) == $past(err_sticky)));

    // R13: every strobe is backed by the matching sticky flag
    p_strobe_flag_r13: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> (err_rule != 4'd0 && err_sticky[err_rule - 4'd1]));

    // R13: at most one new flag per edge
    p_one_new_flag_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(err_sticky & ~$past(err_sticky)) <= 1);

    // R1: nothing is reported for an edge with clock enable low
    p_cke_low_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> !err_valid);

    // R8: a mode set with a busy bank is always flagged
    p_mrs_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == C_MRS && !all_ready && mrd_q == '0)
        |=> (err_valid && err_rule == 4'd2));

endmodule

// File: tb/tb_ddr_cmd_monitor.sv
module tb_ddr_cmd_monitor;

    localparam logic [2:0] K_MRS = 3'b000, K_REF = 3'b001, K_ACT = 3'b011,
                           K_RD  = 3'b101, K_WR  = 3'b100, K_PRE = 3'b010;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_en = 1'b1;
    logic        cs_n = 1'b1;
    logic [2:0]  code = 3'b111;
    logic [1:0]  ba = 2'b00;
    logic        apb = 1'b0;
    logic [3:0]  bank_open;
    logic        err_valid;
    logic [3:0]  err_rule;
    logic [1:0]  err_bank;
    logic [11:0] err_sticky;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    ddr_cmd_monitor dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .clk_en       (clk_en),
        .chip_sel_n   (cs_n),
        .row_strobe_n (code[2]),
        .col_strobe_n (code[1]),
        .wr_en_n      (code[0]),
        .bank_addr    (ba),
        .auto_pre_bit (apb),
        .bank_open    (bank_open),
        .err_valid    (err_valid),
        .err_rule     (err_rule),
        .err_bank     (err_bank),
        .err_sticky   (err_sticky)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; clk_en = 1'b1; cs_n = 1'b1; code = 3'b111; apb = 1'b0; ba = 2'b00;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    // drive one command for one edge; returns at the next falling edge
    task automatic issue(input logic [2:0] k, input logic [1:0] b, input logic ap);
        cs_n = 1'b0; code = k; ba = b; apb = ap;
        @(posedge clk);
        @(negedge clk);
        cs_n = 1'b1; code = 3'b111; apb = 1'b0;
    endtask

    task automatic nops(input int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic expect_err(input int rule, input int bank, input string tag);
        check(err_valid === 1'b1 && err_rule == rule && err_bank == bank, tag,
              int'(err_valid) * 1000 + int'(err_rule) * 10 + int'(err_bank),
              1000 + rule * 10 + bank);
    endtask

    task automatic expect_clean(input string tag);
        check(err_valid === 1'b0, tag, int'(err_valid), 0);
    endtask

    task automatic t_reset();
        do_reset();
        check(err_valid == 0 && err_sticky == 0, "R13 reset error state", int'(err_sticky), 0);
        check(bank_open == 0, "R2 reset banks closed", int'(bank_open), 0);
    endtask

    task automatic t_decode();
        do_reset();
        issue(K_ACT, 2'b10, 0);
        expect_clean("R2 activate bank C");
        check(bank_open == 4'b0100, "R2 bank C index", int'(bank_open), 4);
        clk_en = 1'b0;
        issue(K_RD, 2'b01, 0);
        expect_clean("R1 clock enable low ignored");
        clk_en = 1'b1;
        issue(K_RD, 2'b01, 0);
        expect_clean("R1 first edge after enable ignored");
        check(err_sticky == 0, "R1 nothing recorded", int'(err_sticky), 0);
        issue(K_RD, 2'b01, 0);
        expect_err(8, 1, "R3 read of idle bank");
    endtask

    task automatic t_open_rules();
        do_reset();
        issue(K_ACT, 2'b00, 0);
        nops(1);
        issue(K_ACT, 2'b00, 0);
        expect_err(3, 0, "R3 activate on open bank");
        nops(1);
        check(err_valid == 0, "R13 strobe one cycle", int'(err_valid), 0);
        issue(K_PRE, 2'b01, 0);
        expect_clean("R3 precharge idle bank legal");
        check(bank_open == 4'b0001, "R3 idle precharge no effect", int'(bank_open), 1);
    endtask

    task automatic t_rcd_ras();
        do_reset();
        issue(K_ACT, 2'b01, 0);
        issue(K_RD, 2'b01, 0);
        expect_err(9, 1, "R4 read before tRCD");
        check(err_sticky == 12'h100, "R13 sticky bit for rule 9", int'(err_sticky), 'h100);
        nops(1);
        issue(K_WR, 2'b01, 0);
        expect_clean("R4 write at tRCD");
        do_reset();
        issue(K_ACT, 2'b11, 0);
        nops(1);
        issue(K_PRE, 2'b11, 0);
        expect_err(12, 3, "R5 precharge before tRAS");
    endtask

    task automatic t_rp();
        do_reset();
        issue(K_ACT, 2'b00, 0);
        nops(6);
        issue(K_PRE, 2'b00, 0);
        expect_clean("R5 precharge at tRAS");
        issue(K_ACT, 2'b00, 0);
        expect_err(4, 0, "R6 activate before tRP");
        do_reset();
        issue(K_ACT, 2'b00, 0);
        nops(6);
        issue(K_PRE, 2'b00, 0);
        nops(2);
        issue(K_ACT, 2'b00, 0);
        expect_clean("R6 activate at tRP");
        check(bank_open == 4'b0001, "R6 bank reopened", int'(bank_open), 1);
    endtask

    task automatic t_rrd();
        do_reset();
        issue(K_ACT, 2'b00, 0);
        issue(K_ACT, 2'b01, 0);
        expect_err(7, 1, "R7 activate before tRRD");
        nops(1);
        issue(K_ACT, 2'b10, 0);
        expect_clean("R7 activate at tRRD");
    endtask

    task automatic t_mode();
        do_reset();
        issue(K_ACT, 2'b10, 0);
        nops(6);
        issue(K_MRS, 2'b00, 0);
        expect_err(2, 2, "R8 mode set with open bank");
        do_reset();
        issue(K_REF, 2'b00, 0);
        expect_clean("R8 refresh all idle");
        issue(K_MRS, 2'b00, 0);
        expect_clean("R8 mode set all idle");
        issue(K_ACT, 2'b00, 0);
        expect_err(1, 0, "R9 command inside mode-set gap");
        do_reset();
        issue(K_MRS, 2'b00, 0);
        nops(1);
        issue(K_ACT, 2'b00, 0);
        expect_clean("R9 command at mode-set gap");
    endtask

    task automatic t_pall();
        do_reset();
        issue(K_ACT, 2'b00, 0);
        nops(1);
        issue(K_ACT, 2'b10, 0);
        nops(7);
        issue(K_PRE, 2'b01, 1);
        expect_clean("R10 all-bank precharge legal");
        check(bank_open == 4'b0000, "R10 all banks closed", int'(bank_open), 0);
        nops(2);
        issue(K_MRS, 2'b00, 0);
        expect_clean("R10 mode set after all-bank precharge");
        do_reset();
        issue(K_ACT, 2'b01, 0);
        nops(1);
        issue(K_ACT, 2'b11, 0);
        nops(4);
        issue(K_PRE, 2'b00, 1);
        expect_err(12, 3, "R10 all-bank precharge picks violating bank");
    endtask

    task automatic t_autopre();
        do_reset();
        issue(K_ACT, 2'b00, 0);
        nops(2);
        issue(K_WR, 2'b00, 1);
        expect_clean("R11 write with auto-precharge");
        check(bank_open == 4'b0000, "R11 bank leaves open state", int'(bank_open), 0);
        issue(K_WR, 2'b00, 0);
        expect_err(10, 0, "R11 column access during auto-precharge");
        nops(5);
        issue(K_ACT, 2'b00, 0);
        expect_err(6, 0, "R11 activate before tDAL");
        do_reset();
        issue(K_ACT, 2'b00, 0);
        nops(2);
        issue(K_WR, 2'b00, 1);
        nops(7);
        issue(K_ACT, 2'b00, 0);
        expect_clean("R11 activate at tDAL");
    endtask

    task automatic t_wtr();
        do_reset();
        issue(K_ACT, 2'b00, 0);
        nops(1);
        issue(K_ACT, 2'b01, 0);
        nops(2);
        issue(K_WR, 2'b00, 0);
        issue(K_RD, 2'b01, 0);
        expect_err(11, 1, "R12 read too soon after write");
        nops(1);
        check(err_sticky[10] == 1'b1, "R13 sticky holds", int'(err_sticky[10]), 1);
        issue(K_RD, 2'b01, 0);
        expect_clean("R12 read at write-to-read limit");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_decode();
        t_open_rules();
        t_rcd_ras();
        t_rp();
        t_rrd();
        t_mode();
        t_pall();
        t_autopre();
        t_wtr();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule